// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a single 16-bit counter that serves four jobs, picked by control bits: an up-counting timer that reloads itself on overflow, an up/down counter whose direction comes from an external pin, a free-running counter that latches its value when an external edge arrives, and a baud-rate generator that produces transmit and receive tick pulses for a serial port. Either of two clock-enable inputs paces the counter: a slow timer enable or a fast baud enable. An external count pin can pace it instead. All pin inputs are sampled in the system clock domain.

Software writes the control word, the counter and the reload/capture register through a small write-only register port. Two sticky flags record overflow and external-trigger events. The interrupt output is high while either flag is set. The flags stay set until software writes zero to them.

Top module: `tmr16_multi`

## Requirements
- R1: After synchronous reset the counter, the reload/capture register, both flags, the interrupt and both tick outputs are zero.
- R2: When the count source bit is 0 the counter advances once per cycle with `tick_tmr` high. In baud mode it advances once per cycle with `tick_fast` high and ignores `tick_tmr`. Outside baud mode `tick_fast` is ignored.
- R3: When the count source bit is 1 the counter advances once for each falling edge on `ext_cnt_in`. A falling edge is a high sample followed by a low sample on consecutive clocks. A level held low adds nothing more.
- R4: With the run bit clear the counter does not advance on any count source.
- R5: In reload mode (capture bit, up/down bit and both tick selects clear), a step at FFFFh loads the counter from the reload register and sets the overflow flag.
- R6: With the up/down bit set in reload mode, a high trigger level counts up, reloading at FFFFh. A low trigger level counts down, and a step taken while the counter equals the reload value wraps it to FFFFh. Both wraps set the overflow flag. Trigger edges are not external events in this mode.
- R7: In capture mode an up step at FFFFh wraps the counter to 0000h and sets the overflow flag without touching the capture register.
- R8: With the external-enable bit set, a falling trigger edge sets the external flag. It copies the counter into the capture register in capture mode and loads the counter from the reload register in reload mode. With the bit clear the edge has no effect.
- R9: Either tick-select bit selects baud mode, which takes precedence over the capture bit. In this mode an overflow reloads the counter and leaves the overflow flag alone. One cycle later `tx_tick` pulses if the transmit select is set and `rx_tick` pulses if the receive select is set.
- R10: `irq` is the OR of the two flags. The flags are sticky until software writes zero to them. A hardware set in the same cycle as a software write wins.
- R11: The register port has three addresses: 0 is the control word, 1 is the counter and 2 is the reload/capture register. A software write to the counter wins over any hardware update. The control bits are: bit 0 run, bit 1 count source, bit 2 capture, bit 3 external enable, bit 4 transmit select, bit 5 receive select, bit 6 up/down, bit 7 overflow flag and bit 8 external flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_tmr | input | 1 | Slow timer clock enable |
| tick_fast | input | 1 | Fast baud clock enable |
| ext_cnt_in | input | 1 | External count pin |
| ext_trig_in | input | 1 | External trigger / direction pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| cnt_out | output | 16 | Current counter value |
| rcap_out | output | 16 | Reload/capture register value |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external-event flag |
| irq | output | 1 | Interrupt request |
| tx_tick | output | 1 | Transmit baud tick pulse |
| rx_tick | output | 1 | Receive baud tick pulse |

## Verification
The bench builds the block with its default 16-bit counter width. Every wrap boundary is reached within a few cycles because the counter is preloaded through the register port to values just below FFFFh or just above the reload value. With a reload value of FFFDh in baud mode, the tick period is three fast enables, so the exact tick count over a fixed window can be checked. Holding the count enables low and moving only the trigger pin isolates capture, forced reload and direction from counting.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef struct packed {
        logic ext_flag;
        logic ovf_flag;
        logic updown_en;
        logic rx_sel;
        logic tx_sel;
        logic ext_en;
        logic capture_sel;
        logic count_src;
        logic run;
    } ctl_t;

    localparam int CTL_BITS = $bits(ctl_t);

    typedef enum logic [1:0] {
        MODE_RELOAD  = 2'd0,
        MODE_UPDOWN  = 2'd1,
        MODE_CAPTURE = 2'd2,
        MODE_BAUD    = 2'd3
    } mode_e;

    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_RCAP = 2'd2;

    function automatic mode_e decode_mode(input ctl_t c);
        if (c.tx_sel || c.rx_sel)
            return MODE_BAUD;
        else if (c.capture_sel)
            return MODE_CAPTURE;
        else if (c.updown_en)
            return MODE_UPDOWN;
        else
            return MODE_RELOAD;
    endfunction

endpackage

// File: rtl/tmr16_edge_sampler.sv
module tmr16_edge_sampler #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] level,
    output logic [N-1:0] fall
);
    logic [N-1:0] cur_q;
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                cur_q[i]  <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                cur_q[i]  <= din[i];
                prev_q[i] <= cur_q[i];
            end
        end
        assign level[i] = cur_q[i];
        assign fall[i]  = prev_q[i] & ~cur_q[i];
    end
endmodule

// File: rtl/tmr16_ctl_regs.sv
module tmr16_ctl_regs
    import tmr16_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_ctl,
    input  ctl_t wr_val,
    input  logic ovf_set,
    input  logic ext_set,
    output ctl_t ctl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            if (wr_ctl)
                ctl_q <= wr_val;
            if (ovf_set)
                ctl_q.ovf_flag <= 1'b1;
            if (ext_set)
                ctl_q.ext_flag <= 1'b1;
        end
    end

    // R9
    baud_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (decode_mode(ctl_q) == MODE_BAUD && !ctl_q.ovf_flag && !wr_ctl) |=> !ctl_q.ovf_flag);

    // R8
    ext_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        ext_set |=> ctl_q.ext_flag);
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  mode_e        mode,
    input  logic         run,
    input  logic         count_src,
    input  logic         ext_en,
    input  logic         tick_tmr,
    input  logic         tick_fast,
    input  logic         cnt_fall,
    input  logic         trig_fall,
    input  logic         trig_level,
    input  logic         wr_cnt,
    input  logic         wr_rcap,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] rcap_q,
    output logic         ovf_evt,
    output logic         ext_evt,
    output logic         baud_wrap
);
    localparam logic [W-1:0] ONES = '1;

    logic src_tick, step, down, hit, wrap, trig_evt, trig_reload, trig_capture;
    logic [W-1:0] cnt_d, rcap_d;

    always_comb begin
        if (count_src)
            src_tick = cnt_fall;
        else if (mode == MODE_BAUD)
            src_tick = tick_fast;
        else
            src_tick = tick_tmr;
    end

    assign step         = run & src_tick;
    assign down         = (mode == MODE_UPDOWN) & ~trig_level;
    assign hit          = down ? (cnt_q == rcap_q) : (cnt_q == ONES);
    assign wrap         = step & hit;
    assign trig_evt     = ext_en & trig_fall & (mode != MODE_UPDOWN);
    assign trig_reload  = trig_evt & (mode == MODE_RELOAD);
    assign trig_capture = trig_evt & (mode == MODE_CAPTURE);

    always_comb begin
        cnt_d = cnt_q;
        if (wr_cnt)
            cnt_d = wr_val;
        else if (trig_reload)
            cnt_d = rcap_q;
        else if (step) begin
            if (down)
                cnt_d = hit ? ONES : cnt_q - 1'b1;
            else if (hit)
                cnt_d = (mode == MODE_CAPTURE) ? '0 : rcap_q;
            else
                cnt_d = cnt_q + 1'b1;
        end
    end

    always_comb begin
        rcap_d = rcap_q;
        if (wr_rcap)
            rcap_d = wr_val;
        else if (trig_capture)
            rcap_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            rcap_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            rcap_q <= rcap_d;
        end
    end

    assign ovf_evt   = wrap & (mode != MODE_BAUD) & ~wr_cnt & ~trig_reload;
    assign baud_wrap = wrap & (mode == MODE_BAUD) & ~wr_cnt;
    assign ext_evt   = trig_evt;

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_cnt && !trig_evt && !step) |=> $stable(cnt_q));

    // R5
    reload_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_cnt && !trig_evt && step && mode == MODE_RELOAD && cnt_q == ONES)
        |=> cnt_q == $past(rcap_q));

    // R8
    capture_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_evt && mode == MODE_CAPTURE && !wr_rcap) |=> rcap_q == $past(cnt_q));
endmodule

// File: rtl/tmr16_multi.sv
module tmr16_multi
    import tmr16_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_tmr,
    input  logic              tick_fast,
    input  logic              ext_cnt_in,
    input  logic              ext_trig_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [CNT_W-1:0]  rcap_out,
    output logic              ovf_flag,
    output logic              ext_flag,
    output logic              irq,
    output logic              tx_tick,
    output logic              rx_tick
);
    localparam int PINS = 2;

    logic [PINS-1:0] pin_lvl, pin_fall;
    ctl_t  ctl_q;
    mode_e mode;
    logic  wr_ctl, wr_cnt, wr_rcap;
    logic  ovf_evt, ext_evt, baud_wrap;
    logic  tx_q, rx_q;

    assign wr_ctl  = wr_en && (wr_addr == ADDR_W'(ADDR_CTL));
    assign wr_cnt  = wr_en && (wr_addr == ADDR_W'(ADDR_CNT));
    assign wr_rcap = wr_en && (wr_addr == ADDR_W'(ADDR_RCAP));

    tmr16_edge_sampler #(.N(PINS)) u_pins (
        .clk   (clk),
        .rst   (rst),
        .din   ({ext_trig_in, ext_cnt_in}),
        .level (pin_lvl),
        .fall  (pin_fall)
    );

    tmr16_ctl_regs u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctl  (wr_ctl),
        .wr_val  (ctl_t'(wr_data[CTL_BITS-1:0])),
        .ovf_set (ovf_evt),
        .ext_set (ext_evt),
        .ctl_q   (ctl_q)
    );

    assign mode = decode_mode(ctl_q);

    tmr16_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .run        (ctl_q.run),
        .count_src  (ctl_q.count_src),
        .ext_en     (ctl_q.ext_en),
        .tick_tmr   (tick_tmr),
        .tick_fast  (tick_fast),
        .cnt_fall   (pin_fall[0]),
        .trig_fall  (pin_fall[1]),
        .trig_level (pin_lvl[1]),
        .wr_cnt     (wr_cnt),
        .wr_rcap    (wr_rcap),
        .wr_val     (wr_data),
        .cnt_q      (cnt_out),
        .rcap_q     (rcap_out),
        .ovf_evt    (ovf_evt),
        .ext_evt    (ext_evt),
        .baud_wrap  (baud_wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= 1'b0;
            rx_q <= 1'b0;
        end else begin
            tx_q <= baud_wrap & ctl_q.tx_sel;
            rx_q <= baud_wrap & ctl_q.rx_sel;
        end
    end

    assign tx_tick  = tx_q;
    assign rx_tick  = rx_q;
    assign ovf_flag = ctl_q.ovf_flag;
    assign ext_flag = ctl_q.ext_flag;
    assign irq      = ctl_q.ovf_flag | ctl_q.ext_flag;

    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_ctl) |=> irq);
endmodule

// File: tb/sim_tmr16_multi.sv
`timescale 1ns/1ps
module sim_tmr16_multi;
    logic        clk = 1'b0;
    logic        rst;
    logic        tick_tmr, tick_fast, ext_cnt_in, ext_trig_in;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic [15:0] cnt_out, rcap_out;
    logic        ovf_flag, ext_flag, irq, tx_tick, rx_tick;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    tmr16_multi u0 (
        .clk(clk), .rst(rst), .tick_tmr(tick_tmr), .tick_fast(tick_fast),
        .ext_cnt_in(ext_cnt_in), .ext_trig_in(ext_trig_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_out(cnt_out), .rcap_out(rcap_out), .ovf_flag(ovf_flag),
        .ext_flag(ext_flag), .irq(irq), .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_tmr();
        tick_tmr = 1'b1;
        @(negedge clk);
        tick_tmr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 cnt", cnt_out, 0);
        check("R1 rcap", rcap_out, 0);
        check("R1 flags", {ovf_flag, ext_flag, irq}, 0);
        check("R1 ticks", {tx_tick, rx_tick}, 0);
    endtask

    task automatic t_reload_up();
        wr(2'd2, 16'h1234);
        wr(2'd1, 16'hFFFE);
        wr(2'd0, 16'h0001);
        pulse_tmr();
        check("R2 step", cnt_out, 16'hFFFF);
        check("R5 no flag yet", ovf_flag, 0);
        pulse_tmr();
        check("R5 reload", cnt_out, 16'h1234);
        check("R5 ovf flag", ovf_flag, 1);
        check("R10 irq", irq, 1);
        tick_fast = 1'b1; wait_n(3); tick_fast = 1'b0;
        check("R2 fast ignored", cnt_out, 16'h1234);
        check("R10 sticky", ovf_flag, 1);
        wr(2'd0, 16'h0001);
        check("R10 sw clear", irq, 0);
    endtask

    task automatic t_run_off();
        wr(2'd0, 16'h0000);
        pulse_tmr();
        check("R4 halted", cnt_out, 16'h1234);
    endtask

    task automatic t_ext_count();
        wr(2'd1, 16'h0007);
        wr(2'd0, 16'h0003);
        pulse_tmr();
        check("R3 tick_tmr ignored", cnt_out, 16'h0007);
        ext_cnt_in = 1'b1; wait_n(2);
        ext_cnt_in = 1'b0; wait_n(3);
        check("R3 one edge", cnt_out, 16'h0008);
        wait_n(3);
        check("R3 low hold", cnt_out, 16'h0008);
    endtask

    task automatic t_capture();
        wr(2'd1, 16'h0100);
        wr(2'd0, 16'h000D);
        ext_trig_in = 1'b1; wait_n(2);
        ext_trig_in = 1'b0; wait_n(3);
        check("R8 captured", rcap_out, 16'h0100);
        check("R8 ext flag", ext_flag, 1);
        check("R8 cnt kept", cnt_out, 16'h0100);
        wr(2'd0, 16'h000D);
        wr(2'd1, 16'hFFFF);
        pulse_tmr();
        check("R7 wrap zero", cnt_out, 16'h0000);
        check("R7 ovf", ovf_flag, 1);
        check("R7 rcap kept", rcap_out, 16'h0100);
    endtask

    task automatic t_trig_reload();
        wr(2'd2, 16'h00AA);
        wr(2'd1, 16'h5000);
        wr(2'd0, 16'h0001);
        ext_trig_in = 1'b1; wait_n(2);
        ext_trig_in = 1'b0; wait_n(3);
        check("R8 disabled cnt", cnt_out, 16'h5000);
        check("R8 disabled flag", ext_flag, 0);
        wr(2'd0, 16'h0009);
        ext_trig_in = 1'b1; wait_n(2);
        ext_trig_in = 1'b0; wait_n(3);
        check("R8 forced reload", cnt_out, 16'h00AA);
        check("R8 reload ext flag", ext_flag, 1);
    endtask

    task automatic t_updown();
        wr(2'd2, 16'h0010);
        wr(2'd1, 16'h0012);
        wr(2'd0, 16'h0049);
        wait_n(2);
        pulse_tmr();
        check("R6 down", cnt_out, 16'h0011);
        pulse_tmr();
        check("R6 at reload", cnt_out, 16'h0010);
        check("R6 no flag", ovf_flag, 0);
        pulse_tmr();
        check("R6 down wrap", cnt_out, 16'hFFFF);
        check("R6 down ovf", ovf_flag, 1);
        wr(2'd0, 16'h0049);
        ext_trig_in = 1'b1; wait_n(2);
        pulse_tmr();
        check("R6 up reload", cnt_out, 16'h0010);
        check("R6 up ovf", ovf_flag, 1);
        ext_trig_in = 1'b0; wait_n(3);
        check("R6 edge not event", ext_flag, 0);
        check("R6 cnt after edge", cnt_out, 16'h0010);
    endtask

    task automatic t_baud(input logic [15:0] ctl, input int exp_tx, input int exp_rx, input string tag);
        int ntx = 0;
        int nrx = 0;
        wr(2'd2, 16'hFFFD);
        wr(2'd1, 16'hFFFD);
        wr(2'd0, ctl);
        pulse_tmr();
        check({tag, " tmr ignored"}, cnt_out, 16'hFFFD);
        tick_fast = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            ntx += int'(tx_tick);
            nrx += int'(rx_tick);
        end
        tick_fast = 1'b0;
        check({tag, " tx count"}, ntx, exp_tx);
        check({tag, " rx count"}, nrx, exp_rx);
        check({tag, " no ovf flag"}, ovf_flag, 0);
        check({tag, " reloaded"}, cnt_out, 16'hFFFD);
    endtask

    initial begin
        rst = 1'b1; tick_tmr = 0; tick_fast = 0; ext_cnt_in = 0; ext_trig_in = 0;
        wr_en = 0; wr_addr = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reload_up();
        t_run_off();
        t_ext_count();
        t_capture();
        t_trig_reload();
        t_updown();
        t_baud(16'h0015, 10, 0, "R9 tx");
        t_baud(16'h0021, 0, 10, "R9 rx");
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'hABCD);
        check("R11 cnt write", cnt_out, 16'hABCD);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule